// File: doc/BRIEF.md
# Word-Parallel Polynomial Remainder Engine

This block divides a bit stream by a binary generator polynomial of degree K and keeps the remainder. It is the core of a CRC checker or a systematic BCH parity generator. It takes L message bits in each clock, where a plain shift register would take one. This gives an L-fold speedup at the same clock rate, as long as the wider feedback logic still fits in the cycle.

Each accepted word advances the K-bit state by L serial steps in one update. The update has two parts:
- the state is multiplied by the L-th power of the polynomial's companion matrix;
- each word bit is multiplied by its own precomputed column and added in.

Both matrices are built at elaboration from the `POLY` parameter, so one body of code serves any generator. The caller pulses `start` to load the seed, streams the message in words, and marks the final word. The remainder then appears on `rem` together with `done`, and stays there until the next `start`. The message length must be a multiple of L.

Top module: `parallel_rem_engine`

## Requirements
- R1: After reset, `rem` equals the `INIT` parameter and `done` is 0.
- R2: A cycle with `start` high and `in_valid` low sets `rem` to `INIT` and `done` to 0 in the next cycle. This discards any message in progress.
- R3: One accepted word changes `rem` to the state of a serial divider after L bit steps. The serial divider starts from the previous `rem` and takes the word bits from `in_word[L-1]` (first in time) down to `in_word[0]`. One serial step is: `fb = s[K-1] ^ bit`, then `s = {s[K-2:0],0} ^ (fb ? POLY : 0)`. Bit i of `POLY` is the coefficient of x^i, and x^K is implicit.
- R4: After a message of several words, `rem` equals the serial remainder of the whole message, fed most significant bit first. This includes an all-zero message from a zero seed, which leaves 0.
- R5: `done` goes high in the cycle after a word accepted with `in_last` high. While `done` is high and `start` is low, `rem` and `done` hold, and further valid words are ignored.
- R6: A valid word is ignored when no message is open: after reset, or after the final word, with `start` low.
- R7: When `start` and `in_valid` are high in the same cycle, the word is applied to `INIT`, not to the old state. If `in_last` is also high, `done` is 1 in the next cycle.
- R8: A cycle with `in_valid` low and `start` low leaves `rem` unchanged, so words may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new message and reloads the seed |
| in_valid | input | 1 | `in_word` holds a message word this cycle |
| in_last | input | 1 | The current valid word is the final one |
| in_word | input | L | Message word; bit L-1 is earliest in time |
| rem | output | K | Running state; the remainder once `done` is high |
| done | output | 1 | Remainder complete and held |

## Verification
The two functions that can fall in the same cycle are reseeding and word absorption. The bench provokes this by raising `start` together with `in_valid` while a previous, different remainder is still held. It does this both with and without `in_last`. The result is judged against a serial model seeded from `INIT`, so a design that absorbs the word into the stale state, or drops the word, shows a different remainder or a wrong `done`.

// File: rtl/parallel_rem_engine.sv
module parallel_rem_engine #(
  parameter int K = 16,
  parameter int L = 16,
  parameter logic [K-1:0] POLY = 16'hC007,
  parameter logic [K-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         in_valid,
  input  logic         in_last,
  input  logic [L-1:0] in_word,
  output logic [K-1:0] rem,
  output logic         done
);

  // one serial step of the companion matrix
  function automatic logic [K-1:0] step_a(input logic [K-1:0] v);
    return {v[K-2:0], 1'b0} ^ (v[K-1] ? POLY : {K{1'b0}});
  endfunction

  // columns of A^L, column j at [j*K +: K]
  function automatic logic [K*K-1:0] build_al();
    logic [K*K-1:0] m;
    logic [K-1:0] c;
    m = '0;
    for (int j = 0; j < K; j++) begin
      c = '0;
      c[j] = 1'b1;
      for (int n = 0; n < L; n++) c = step_a(c);
      m[j*K +: K] = c;
    end
    return m;
  endfunction

  // columns A^j * b, weighting in_word[j]
  function automatic logic [K*L-1:0] build_bl();
    logic [K*L-1:0] m;
    logic [K-1:0] c;
    m = '0;
    c = POLY;
    for (int j = 0; j < L; j++) begin
      m[j*K +: K] = c;
      c = step_a(c);
    end
    return m;
  endfunction

  localparam logic [K*K-1:0] AL = build_al();
  localparam logic [K*L-1:0] BL = build_bl();

  logic [K-1:0] state, seed, nxt;
  logic         open_msg;
  wire          take = in_valid & (start | open_msg);

  assign seed = start ? INIT : state;
  assign rem  = state;

  always_comb begin
    nxt = '0;
    for (int j = 0; j < K; j++) if (seed[j]) nxt ^= AL[j*K +: K];
    for (int j = 0; j < L; j++) if (in_word[j]) nxt ^= BL[j*K +: K];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= INIT;
      open_msg <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (take) state <= nxt;
      else if (start) state <= INIT;
      if (take && in_last) begin
        open_msg <= 1'b0;
        done     <= 1'b1;
      end else if (start) begin
        open_msg <= 1'b1;
        done     <= 1'b0;
      end
    end
  end

  assert_reseed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !in_valid |=> rem == INIT && !done);
  assert_done_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_last |=> done);
  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(rem));
  assert_idle_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !open_msg && !start |=> $stable(rem));
  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !start |=> $stable(rem));
  assert_collide_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && in_valid && !in_last |=> !done);

endmodule

// File: tb/parallel_rem_engine_test.sv
module parallel_rem_engine_test;
  localparam int K = 16;
  localparam int L = 16;
  localparam logic [K-1:0] POLY = 16'hC007;
  localparam logic [K-1:0] INIT = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [L-1:0] in_word = '0;
  logic [K-1:0] rem;
  logic done;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  parallel_rem_engine #(.K(K), .L(L), .POLY(POLY), .INIT(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .in_word(in_word), .rem(rem), .done(done));

  function automatic logic [K-1:0] ser(input logic [K-1:0] s, input logic [L-1:0] w);
    logic fb;
    for (int i = L-1; i >= 0; i--) begin
      fb = s[K-1] ^ w[i];
      s = {s[K-2:0], 1'b0} ^ (fb ? POLY : {K{1'b0}});
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [K-1:0] got, input logic [K-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic l, input logic [L-1:0] w);
    start = s; in_valid = v; in_last = l; in_word = w;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_word = '0;
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk("R1 rem", rem, INIT);
    chk("R1 done", {15'd0, done}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(0, 1, 0, 16'hBEEF);
    chk("R6 idle word after reset", rem, INIT);
    drive(0, 1, 1, 16'h1357);
    chk("R6 idle last after reset", rem, INIT);
    chk("R6 idle done", {15'd0, done}, 16'd0);
  endtask

  task automatic t_single();
    logic [K-1:0] e;
    drive(1, 0, 0, '0);
    chk("R2 seed", rem, INIT);
    e = ser(INIT, 16'h1234);
    drive(0, 1, 1, 16'h1234);
    chk("R3 one word", rem, e);
    chk("R5 done rises", {15'd0, done}, 16'd1);
  endtask

  task automatic t_multi();
    logic [K-1:0] e;
    logic [L-1:0] w [4] = '{16'hA5A5, 16'h0001, 16'h8000, 16'hFFFF};
    drive(1, 0, 0, '0);
    chk("R2 done cleared", {15'd0, done}, 16'd0);
    e = INIT;
    for (int i = 0; i < 4; i++) begin
      e = ser(e, w[i]);
      drive(0, 1, i == 3, w[i]);
      chk("R3 partial", rem, e);
      if (i < 3) begin
        drive(0, 0, 0, 16'h5555);
        chk("R8 gap hold", rem, e);
        chk("R5 not done mid", {15'd0, done}, 16'd0);
      end
    end
    chk("R4 multi result", rem, e);
    chk("R5 done after last", {15'd0, done}, 16'd1);
  endtask

  task automatic t_hold();
    logic [K-1:0] h;
    h = rem;
    drive(0, 1, 0, 16'h7777);
    chk("R5 hold rem", rem, h);
    drive(0, 1, 1, 16'h0F0F);
    chk("R6 ignored after done", rem, h);
    chk("R5 hold done", {15'd0, done}, 16'd1);
  endtask

  task automatic t_collide();
    logic [K-1:0] e;
    e = ser(INIT, 16'h4321);
    drive(1, 1, 0, 16'h4321);
    chk("R7 start+word rem", rem, e);
    chk("R7 start+word done", {15'd0, done}, 16'd0);
    e = ser(e, 16'h00FF);
    drive(0, 1, 1, 16'h00FF);
    chk("R7 continue", rem, e);
    e = ser(INIT, 16'hCAFE);
    drive(1, 1, 1, 16'hCAFE);
    chk("R7 single-word message", rem, e);
    chk("R7 done", {15'd0, done}, 16'd1);
  endtask

  task automatic t_restart();
    drive(1, 0, 0, '0);
    drive(0, 1, 0, 16'h9999);
    drive(1, 0, 0, '0);
    chk("R2 discard open message", rem, INIT);
    for (int i = 0; i < 3; i++) drive(0, 1, i == 2, 16'h0000);
    chk("R4 zero message", rem, 16'h0000);
  endtask

  task automatic t_random();
    logic [K-1:0] e;
    logic [L-1:0] w;
    int n;
    for (int m = 0; m < 8; m++) begin
      n = 1 + (m % 6);
      drive(1, 0, 0, '0);
      e = INIT;
      for (int i = 0; i < n; i++) begin
        w = L'($urandom);
        e = ser(e, w);
        drive(0, 1, i == n-1, w);
      end
      chk("R4 random message", rem, e);
      chk("R5 random done", {15'd0, done}, 16'd1);
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_hold();
    t_collide();
    t_restart();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule